// File: doc/BRIEF.md
# Serial Port Register File with Interrupt

This block is the software-facing half of a simple serial port: a bank of word-indexed registers on a 32-bit bus, a one-character receive slot, and a transmit data register. The character stream itself enters and leaves through two small handshakes. Bit timing, framing, baud generation and queueing all belong to a neighbouring serializer. Software programs the control words. It polls or takes an interrupt from two status words, pulls received characters from the receive data word, and pushes bytes into the transmit data word.

The bus is a plain strobe interface. `addr` is the word index, which is the byte offset divided by four, within a 4 KB window. A write strobe commits `wdata` at the clock edge. `rdata` is combinational from `addr`. A read of the receive data word has a side effect, and that side effect is committed at the edge that ends a cycle in which `rd_en` is high. The baud, modulator, FIFO-control and millisecond words are storage only. A single level interrupt is formed from status flags and their enable bits. An active-low soft-reset bit in control word 2 returns the block to its reset state. `rst_n` is asynchronous and is expected to be released in step with `clk`.

Top module: `uart_regfile`

## Requirements
- R1: After `rst_n` the reads return the following: status 1 (index 0x25) = 0x6040 (transmit-ready bit 13, RTS-status bit 14, receiver-idle bit 6); status 2 (0x26) = 0x4028 (TX-FIFO-empty bit 14, transmit-complete bit 3, carrier-detect bit 5); test (0x2D) = 0x0060 (RX-empty bit 5, TX-empty bit 6); control 1 (0x20) = 0; control 2 (0x21) = 0x0001 (soft-reset bit 0); control 3 (0x22) = 0x0700; modulator (0x2A) = 0; baud count (0x2B) = 4; receive data (0x00) = 0x4000 (error bit 14). `irq` is 0 and `rx_ready` is 1.
- R2: A write to control 1, 2, 3 or 4 (0x20–0x23), FIFO control (0x24), modulator (0x2A) or millisecond (0x2C) stores `wdata[15:0]`. A later read returns that value with bits 31:16 at zero. Index 0x29 always reads 0, and a write to it loads the baud count word.
- R3: A read of an unmapped index returns 0. Writes to an unmapped index, to the baud count (0x2B) and to the test word (0x2D) change nothing that can be read back.
- R4: A write to transmit data (0x10) sends a byte only when control 2 bit 2 (transmit enable) is 1 and no earlier byte is still waiting. Otherwise the write is dropped and `tx_valid` stays low.
- R5: An accepted transmit write raises `tx_valid` for exactly one cycle on the next cycle, with `tx_data` = `wdata[7:0]`. Status 1 bit 13 and status 2 bit 3 read 0 from that cycle until a cycle in which `tx_ready` is 1 has ended.
- R6: `rx_ready` is 1 exactly while the receive slot is empty. `rx_valid` with `rx_ready` stores the character, sets status 1 bit 9 and status 2 bit 0, and clears test bit 5. While the slot is full, `rx_valid` is ignored.
- R7: A read of index 0x00 while the slot is full returns the stored word with bit 15 set, and empties the slot. A read while the slot is empty returns the stored word without bit 15 and has no effect.
- R8: `rx_valid` with `rx_break` stores 0x5800 (break bit 11, frame-error bit 12, error bit 14) and sets status 2 bit 2 (break detect).
- R9: A write to status 1 or status 2 clears each event flag whose `wdata` bit is 1. Status 1 bits 13, 14, 9 and 6 do not respond to such writes, and neither do status 2 bits 14, 5, 3 and 0.
- R10: `irq` is 1 when any of the following holds. Status 1 bit 13 or bit 9 is set together with the same bit of control 1. Status 2 bit 14 is set together with control 1 bit 6. Status 2 bit 3 or bit 0 is set together with the same bit of control 4.
- R11: A control 2 write with bit 0 at 0 restores the R1 values of status 1, status 2, the test word, control 1, control 3, modulator, baud count and the receive slot, and cancels any pending transmit. Control 2 then holds `wdata[15:0]` with bit 0 forced to 1. Control 4, FIFO control and millisecond keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | IDX_W | Word index (byte offset / 4) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| tx_valid | output | 1 | One-cycle pulse presenting a transmit byte |
| tx_data | output | CHAR_W | Transmit byte |
| tx_ready | input | 1 | Serializer has taken the byte |
| rx_valid | input | 1 | Received character present |
| rx_data | input | CHAR_W | Received character |
| rx_break | input | 1 | Received event is a break |
| rx_ready | output | 1 | Receive slot is empty |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `rx_valid` is offered only as a one-cycle strobe from a source that respects `rx_ready`. They also assume that no soft-reset write lands in the same cycle as a receive or a receive-data read, since either event would then see its flag effect overridden. The stimulus drives every bus access, receive strobe and break as a separate cycle with an idle cycle between, so these cases never overlap. Transmit-ready is held low only around the one transmit that checks the waiting state, and the bench raises it again before any further transmit is expected.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  // Word indices
  localparam int IX_RXD = 'h000;
  localparam int IX_TXD = 'h010;
  localparam int IX_CR1 = 'h020;
  localparam int IX_CR2 = 'h021;
  localparam int IX_CR3 = 'h022;
  localparam int IX_CR4 = 'h023;
  localparam int IX_FCR = 'h024;
  localparam int IX_SR1 = 'h025;
  localparam int IX_SR2 = 'h026;
  localparam int IX_BIR = 'h029;
  localparam int IX_BMR = 'h02A;
  localparam int IX_BRC = 'h02B;
  localparam int IX_OMS = 'h02C;
  localparam int IX_TST = 'h02D;

  // Status 1 / control 1 shared positions
  localparam int B_TRDY = 13;
  localparam int B_RRDY = 9;
  localparam int B_RTSS = 14;
  localparam int B_RXDS = 6;
  localparam int B_CR1_TXEIE = 6;

  // Status 2 / control 4 shared positions
  localparam int B_RDR  = 0;
  localparam int B_BRCD = 2;
  localparam int B_TXDC = 3;
  localparam int B_DCDI = 5;
  localparam int B_TXFE = 14;
  localparam int B_CR4_RDIE = 0;
  localparam int B_CR4_TCIE = 3;

  // Control 2
  localparam int B_SRST = 0;
  localparam int B_TXEN = 2;

  // Test word
  localparam int B_RXE = 5;
  localparam int B_TXE = 6;

  // Receive data word
  localparam int B_CHRDY = 15;
  localparam int B_ERR   = 14;
  localparam int B_FRM   = 12;
  localparam int B_BRK   = 11;

  // Event flags clearable by writing one
  localparam logic [15:0] SR1_W1C = 16'h9DB0;
  localparam logic [15:0] SR2_W1C = 16'hBDD6;

  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_WAIT} tx_state_e;

endpackage

// File: rtl/uart_rf_tx.sv
module uart_rf_tx
  import uart_rf_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              start,
  input  logic [CHAR_W-1:0] start_byte,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data,
  output logic              idle
);

  tx_state_e         state_q, state_d;
  logic [CHAR_W-1:0] data_q, data_d;
  logic              data_en;

  always_comb begin
    state_d = state_q;
    data_en = 1'b0;
    data_d  = start_byte;
    if (soft_clr) begin
      state_d = TX_IDLE;
    end else begin
      unique case (state_q)
        TX_IDLE: if (start) begin
          state_d = TX_SEND;
          data_en = 1'b1;
        end
        TX_SEND: state_d = tx_ready ? TX_IDLE : TX_WAIT;
        TX_WAIT: if (tx_ready) state_d = TX_IDLE;
        default: state_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign tx_valid = (state_q == TX_SEND);
  assign tx_data  = data_q;
  assign idle     = (state_q == TX_IDLE);

endmodule

// File: rtl/uart_rf_rx.sv
module uart_rf_rx
  import uart_rf_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_break,
  input  logic              take,
  output logic              full,
  output logic [REG_W-1:0]  slot,
  output logic              brk_seen
);

  localparam logic [REG_W-1:0] SLOT_RST = REG_W'(1) << B_ERR;
  localparam logic [REG_W-1:0] SLOT_BRK =
    (REG_W'(1) << B_ERR) | (REG_W'(1) << B_FRM) | (REG_W'(1) << B_BRK);

  logic             full_q, full_d;
  logic [REG_W-1:0] slot_q, slot_d;
  logic             accept;

  assign accept = rx_valid && !full_q;

  always_comb begin
    full_d = full_q;
    slot_d = slot_q;
    if (soft_clr) begin
      full_d = 1'b0;
      slot_d = SLOT_RST;
    end else if (accept) begin
      full_d = 1'b1;
      slot_d = rx_break ? SLOT_BRK : REG_W'(rx_data);
    end else if (take && full_q) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      slot_q <= SLOT_RST;
    end else begin
      full_q <= full_d;
      slot_q <= slot_d;
    end
  end

  assign full     = full_q;
  assign slot     = slot_q;
  assign brk_seen = accept && rx_break && !soft_clr;

endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic [REG_W-1:0] sr1,
  input  logic [REG_W-1:0] sr2,
  input  logic [REG_W-1:0] cr1,
  input  logic [REG_W-1:0] cr4,
  output logic             irq
);

  logic [REG_W-1:0] sel1, sel2;

  always_comb begin
    sel1 = '0;
    sel1[B_TRDY] = 1'b1;
    sel1[B_RRDY] = 1'b1;
    sel2 = '0;
    sel2[B_TXFE] = cr1[B_CR1_TXEIE];
    sel2[B_TXDC] = cr4[B_CR4_TCIE];
    sel2[B_RDR]  = cr4[B_CR4_RDIE];
    irq = (|(sr1 & cr1 & sel1)) || (|(sr2 & sel2));
  end

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32,
  parameter int REG_W  = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_break,
  output logic              rx_ready,
  output logic              irq
);

  localparam logic [REG_W-1:0] CR2_RST = REG_W'(1) << B_SRST;
  localparam logic [REG_W-1:0] CR3_RST = REG_W'('h0700);
  localparam logic [REG_W-1:0] BRC_RST = REG_W'(4);
  localparam logic [REG_W-1:0] SR1_RST = (REG_W'(1) << B_RXDS) | (REG_W'(1) << B_RTSS);
  localparam logic [REG_W-1:0] SR2_RST = (REG_W'(1) << B_TXFE) | (REG_W'(1) << B_DCDI);
  localparam logic [REG_W-1:0] SR1_CLR = REG_W'(SR1_W1C);
  localparam logic [REG_W-1:0] SR2_CLR = REG_W'(SR2_W1C);

  logic [REG_W-1:0] wlo;
  logic             unused_hi;
  assign wlo       = wdata[REG_W-1:0];
  assign unused_hi = ^wdata[DATA_W-1:REG_W];

  function automatic logic at(input logic [IDX_W-1:0] a, input int ix);
    return a == IDX_W'(ix);
  endfunction

  // Register state
  logic [REG_W-1:0] cr1_q, cr2_q, cr3_q, cr4_q, fcr_q, bmr_q, brc_q, oms_q;
  logic [REG_W-1:0] sr1_q, sr2_q;
  logic [REG_W-1:0] cr1_d, cr2_d, cr3_d, cr4_d, fcr_d, bmr_d, brc_d, oms_d;
  logic [REG_W-1:0] sr1_d, sr2_d;
  logic             cr1_en, cr2_en, cr3_en, cr4_en, fcr_en, bmr_en, brc_en, oms_en;

  logic soft_clr, tx_start, rx_take, tx_idle, rx_full, brk_seen;
  logic [REG_W-1:0] rx_slot;
  logic [REG_W-1:0] sr1_v, sr2_v, tst_v, rxd_v;

  assign soft_clr = wr_en && at(addr, IX_CR2) && !wlo[B_SRST];
  assign tx_start = wr_en && at(addr, IX_TXD) && cr2_q[B_TXEN];
  assign rx_take  = rd_en && at(addr, IX_RXD);

  uart_rf_tx #(.CHAR_W(CHAR_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_clr   (soft_clr),
    .start      (tx_start),
    .start_byte (wdata[CHAR_W-1:0]),
    .tx_ready   (tx_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .idle       (tx_idle)
  );

  uart_rf_rx #(.CHAR_W(CHAR_W), .REG_W(REG_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_break (rx_break),
    .take     (rx_take),
    .full     (rx_full),
    .slot     (rx_slot),
    .brk_seen (brk_seen)
  );

  // Composed read views
  always_comb begin
    sr1_v = sr1_q;
    sr1_v[B_TRDY] = tx_idle;
    sr1_v[B_RRDY] = rx_full;
    sr2_v = sr2_q;
    sr2_v[B_TXDC] = tx_idle;
    sr2_v[B_RDR]  = rx_full;
    tst_v = '0;
    tst_v[B_RXE] = !rx_full;
    tst_v[B_TXE] = 1'b1;
    rxd_v = rx_slot;
    rxd_v[B_CHRDY] = rx_full;
  end

  // Next state
  always_comb begin
    cr1_en = wr_en && at(addr, IX_CR1);
    cr2_en = wr_en && at(addr, IX_CR2);
    cr3_en = wr_en && at(addr, IX_CR3);
    cr4_en = wr_en && at(addr, IX_CR4);
    fcr_en = wr_en && at(addr, IX_FCR);
    bmr_en = wr_en && at(addr, IX_BMR);
    brc_en = wr_en && at(addr, IX_BIR);
    oms_en = wr_en && at(addr, IX_OMS);

    cr1_d = wlo;
    cr2_d = wlo | CR2_RST;
    cr3_d = wlo;
    cr4_d = wlo;
    fcr_d = wlo;
    bmr_d = wlo;
    brc_d = wlo;
    oms_d = wlo;

    if (soft_clr) begin
      cr1_en = 1'b1; cr1_d = '0;
      cr3_en = 1'b1; cr3_d = CR3_RST;
      bmr_en = 1'b1; bmr_d = '0;
      brc_en = 1'b1; brc_d = BRC_RST;
    end

    sr1_d = sr1_q;
    sr2_d = sr2_q;
    if (soft_clr) begin
      sr1_d = SR1_RST;
      sr2_d = SR2_RST;
    end else begin
      if (wr_en && at(addr, IX_SR1)) sr1_d = sr1_q & ~(wlo & SR1_CLR);
      if (wr_en && at(addr, IX_SR2)) sr2_d = sr2_q & ~(wlo & SR2_CLR);
      if (brk_seen) sr2_d[B_BRCD] = 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr1_q <= '0;
      cr2_q <= CR2_RST;
      cr3_q <= CR3_RST;
      cr4_q <= '0;
      fcr_q <= '0;
      bmr_q <= '0;
      brc_q <= BRC_RST;
      oms_q <= '0;
      sr1_q <= SR1_RST;
      sr2_q <= SR2_RST;
    end else begin
      if (cr1_en) cr1_q <= cr1_d;
      if (cr2_en) cr2_q <= cr2_d;
      if (cr3_en) cr3_q <= cr3_d;
      if (cr4_en) cr4_q <= cr4_d;
      if (fcr_en) fcr_q <= fcr_d;
      if (bmr_en) bmr_q <= bmr_d;
      if (brc_en) brc_q <= brc_d;
      if (oms_en) oms_q <= oms_d;
      sr1_q <= sr1_d;
      sr2_q <= sr2_d;
    end
  end

  // Read mux
  always_comb begin
    logic [REG_W-1:0] v;
    v = '0;
    if      (at(addr, IX_RXD)) v = rxd_v;
    else if (at(addr, IX_CR1)) v = cr1_q;
    else if (at(addr, IX_CR2)) v = cr2_q;
    else if (at(addr, IX_CR3)) v = cr3_q;
    else if (at(addr, IX_CR4)) v = cr4_q;
    else if (at(addr, IX_FCR)) v = fcr_q;
    else if (at(addr, IX_SR1)) v = sr1_v;
    else if (at(addr, IX_SR2)) v = sr2_v;
    else if (at(addr, IX_BMR)) v = bmr_q;
    else if (at(addr, IX_BRC)) v = brc_q;
    else if (at(addr, IX_OMS)) v = oms_q;
    else if (at(addr, IX_TST)) v = tst_v;
    rdata = DATA_W'(v);
  end

  assign rx_ready = !rx_full;

  uart_rf_irq #(.REG_W(REG_W)) u_irq (
    .sr1 (sr1_v),
    .sr2 (sr2_v),
    .cr1 (cr1_q),
    .cr4 (cr4_q),
    .irq (irq)
  );

endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk
  import uart_rf_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32,
  parameter int REG_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [IDX_W-1:0]  addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              tx_valid,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              irq,
  input logic [REG_W-1:0]  cr1_q,
  input logic [REG_W-1:0]  cr2_q,
  input logic [REG_W-1:0]  cr4_q
);

  logic srst_wr;
  logic unused_w;
  assign srst_wr  = wr_en && (addr == IDX_W'(IX_CR2)) && !wdata[B_SRST];
  assign unused_w = ^wdata[DATA_W-1:1];

  AST_TX_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid); // R5

  AST_TX_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == IDX_W'(IX_TXD) && !cr2_q[B_TXEN]) |=> !tx_valid); // R4

  AST_RX_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !srst_wr) |=> !rx_ready); // R6

  AST_RX_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == IDX_W'(IX_RXD) && !rx_ready) |=> rx_ready); // R7

  AST_SRST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == IDX_W'(IX_CR2)) |=> cr2_q[B_SRST]); // R11

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cr1_q[B_TRDY] && !cr1_q[B_RRDY] && !cr1_q[B_CR1_TXEIE] &&
     !cr4_q[B_CR4_TCIE] && !cr4_q[B_CR4_RDIE]) |-> !irq); // R10

  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rdata[DATA_W-1:REG_W] == '0)); // R2

endmodule

bind uart_regfile uart_regfile_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .tx_valid (tx_valid),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .irq      (irq),
  .cr1_q    (cr1_q),
  .cr2_q    (cr2_q),
  .cr4_q    (cr4_q)
);

// File: tb/uart_regfile_bench.sv
module uart_regfile_bench;

  localparam logic [9:0] A_RXD = 10'h000, A_TXD = 10'h010, A_CR1 = 10'h020,
                         A_CR2 = 10'h021, A_CR3 = 10'h022, A_CR4 = 10'h023,
                         A_FCR = 10'h024, A_SR1 = 10'h025, A_SR2 = 10'h026,
                         A_BIR = 10'h029, A_BMR = 10'h02A, A_BRC = 10'h02B,
                         A_OMS = 10'h02C, A_TST = 10'h02D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        tx_ready = 1'b1;
  logic        rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [31:0] rdata;
  logic        tx_valid, rx_ready, irq;
  logic [7:0]  tx_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic [31:0] rd_exp_q[$];
  string       rd_tag_q[$];
  logic [7:0]  tx_exp_q[$];
  string       tx_tag_q[$];

  always #5 clk = ~clk;

  uart_regfile u_uart_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .rx_ready(rx_ready), .irq(irq)
  );

  // Monitor: pops expectations as results appear
  always @(negedge clk) begin
    logic [31:0] e;
    logic [7:0]  b;
    string       t;
    #1;
    if (rd_en && rd_exp_q.size() > 0) begin
      e = rd_exp_q.pop_front();
      t = rd_tag_q.pop_front();
      n_cmp++;
      if (rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata=%h expected %h", t, rdata, e);
      end
    end
    if (tx_valid) begin
      n_cmp++;
      if (tx_exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R4: tx_valid with byte %h, expected no transmit", tx_data);
      end else begin
        b = tx_exp_q.pop_front();
        t = tx_tag_q.pop_front();
        if (tx_data !== b) begin
          n_bad++;
          $display("FAIL %s: tx_data=%h expected %h", t, tx_data, b);
        end
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    rd_exp_q.push_back(e);
    rd_tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input bit expect_out, input string t);
    if (expect_out) begin
      tx_exp_q.push_back(d);
      tx_tag_q.push_back(t);
    end
    wr(A_TXD, {24'hABCDEF, d});
  endtask

  task automatic recv(input logic [7:0] d, input logic brk);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_break = brk;
    @(negedge clk);
    rx_valid = 1'b0; rx_break = 1'b0;
  endtask

  task automatic chk(input string t, input logic act, input logic e);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: value=%b expected %b", t, act, e);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #200_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    settle();
    chk("R1 irq", irq, 1'b0);
    chk("R1 rx_ready", rx_ready, 1'b1);
    rd(A_SR1, 32'h6040, "R1 status1");
    rd(A_SR2, 32'h4028, "R1 status2");
    rd(A_TST, 32'h0060, "R1 test");
    rd(A_CR1, 32'h0000, "R1 ctrl1");
    rd(A_CR2, 32'h0001, "R1 ctrl2");
    rd(A_CR3, 32'h0700, "R1 ctrl3");
    rd(A_BMR, 32'h0000, "R1 modulator");
    rd(A_BRC, 32'h0004, "R1 baud count");
    rd(A_RXD, 32'h4000, "R1 rx data");

    // R2 storage of low half
    wr(A_CR3, 32'h1234ABCD); rd(A_CR3, 32'h0000ABCD, "R2 ctrl3");
    wr(A_FCR, 32'hFFFF0A81); rd(A_FCR, 32'h00000A81, "R2 fifo ctrl");
    wr(A_OMS, 32'h00017777); rd(A_OMS, 32'h00007777, "R2 millisecond");
    wr(A_BMR, 32'h00000321); rd(A_BMR, 32'h00000321, "R2 modulator");
    wr(A_BIR, 32'h00012345); rd(A_BRC, 32'h00002345, "R2 increment loads count");
    rd(A_BIR, 32'h0, "R2 increment reads zero");

    // R3 unmapped and read-only
    wr(A_BRC, 32'h99); rd(A_BRC, 32'h00002345, "R3 count write ignored");
    wr(10'h027, 32'hFFFF); rd(10'h027, 32'h0, "R3 unmapped");
    rd(10'h3FF, 32'h0, "R3 unmapped top");
    wr(A_TST, 32'h0); rd(A_TST, 32'h0060, "R3 test write ignored");

    // R4 transmit disabled
    send(8'h41, 1'b0, "R4");
    repeat (3) @(negedge clk);

    // R5 transmit handshake
    wr(A_CR2, 32'h5);
    send(8'h55, 1'b1, "R5 byte 55");
    rd(A_SR1, 32'h6040, "R5 ready restored");
    tx_ready = 1'b0;
    send(8'hA5, 1'b1, "R5 byte A5");
    rd(A_SR1, 32'h4040, "R5 ready low while waiting");
    send(8'h11, 1'b0, "R4 busy");
    rd(A_SR2, 32'h4020, "R5 complete low while waiting");
    tx_ready = 1'b1;
    rd(A_SR1, 32'h6040, "R5 ready after handshake");
    rd(A_SR2, 32'h4028, "R5 complete after handshake");

    // R10 interrupt sources
    wr(A_CR1, 32'h2000); settle(); chk("R10 tx ready irq", irq, 1'b1);
    wr(A_CR1, 32'h0000); settle(); chk("R10 masked", irq, 1'b0);
    wr(A_CR4, 32'h0008); settle(); chk("R10 tx complete irq", irq, 1'b1);
    wr(A_CR4, 32'h0000);
    wr(A_CR1, 32'h0040); settle(); chk("R10 fifo empty irq", irq, 1'b1);
    wr(A_CR1, 32'h0200); settle(); chk("R10 rx ready irq idle", irq, 1'b0);
    wr(A_CR1, 32'h0000);

    // R6 / R7 receive slot
    wr(A_CR4, 32'h0001);
    settle(); chk("R10 rx enable no data", irq, 1'b0);
    recv(8'h3C, 1'b0);
    settle();
    chk("R6 rx_ready low", rx_ready, 1'b0);
    chk("R10 rx data irq", irq, 1'b1);
    rd(A_TST, 32'h0020 ^ 32'h0060, "R6 rx empty cleared");
    rd(A_SR1, 32'h6240, "R6 status1 rx ready");
    recv(8'h77, 1'b0);
    rd(A_RXD, 32'h803C, "R7 first read");
    settle();
    chk("R7 irq cleared", irq, 1'b0);
    chk("R7 rx_ready", rx_ready, 1'b1);
    rd(A_RXD, 32'h003C, "R7 empty read no effect");
    rd(A_SR2, 32'h4028, "R7 status2 after read");

    // R8 break
    recv(8'h99, 1'b1);
    rd(A_SR2, 32'h402D, "R8 break flags");
    rd(A_RXD, 32'hD800, "R8 break word");
    rd(A_SR2, 32'h402C, "R8 break detect held");

    // R9 write-one-to-clear
    wr(A_SR2, 32'hFFFF); rd(A_SR2, 32'h4028, "R9 status2 clear");
    wr(A_SR1, 32'hFFFF); rd(A_SR1, 32'h6040, "R9 status1 fixed bits");

    // R11 soft reset
    wr(A_CR1, 32'h2000); wr(A_CR3, 32'h5); wr(A_BMR, 32'h7);
    recv(8'h12, 1'b0);
    wr(A_CR2, 32'h0004);
    settle();
    chk("R11 rx_ready", rx_ready, 1'b1);
    chk("R11 irq", irq, 1'b0);
    rd(A_CR2, 32'h0005, "R11 ctrl2 readback");
    rd(A_CR1, 32'h0000, "R11 ctrl1");
    rd(A_CR3, 32'h0700, "R11 ctrl3");
    rd(A_BMR, 32'h0000, "R11 modulator");
    rd(A_BRC, 32'h0004, "R11 baud count");
    rd(A_RXD, 32'h4000, "R11 rx data");
    rd(A_SR1, 32'h6040, "R11 status1");
    rd(A_SR2, 32'h4028, "R11 status2");
    rd(A_FCR, 32'h0A81, "R11 fifo ctrl kept");
    rd(A_CR4, 32'h0001, "R11 ctrl4 kept");
    send(8'h66, 1'b1, "R11 enable from written value");
    repeat (3) @(negedge clk);

    if (rd_exp_q.size() != 0 || tx_exp_q.size() != 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R5: %0d transmits outstanding, expected 0", tx_exp_q.size());
    end
    done = 1'b1;
    finish_run();
  end

endmodule